// File: doc/BRIEF.md
# FIFO Almost-Empty / Almost-Full Offset Loader

This block holds the two threshold offsets that a FIFO's flag logic compares against: the almost-empty offset and the almost-full offset. Each offset has its own register. The flag comparison is not part of this block; it only publishes the two current offset values.

While master reset is asserted, three strap inputs select one of eight default offset values, and both registers take that value. The strap inputs are the two flag-select bits and the load input. The level of the load input during reset also fixes how software may change the offsets later. In serial mode, one bit per clock enters from a pin that is shared with the FIFO's reset-time mode strap. In parallel mode, the write bus loads the registers and a read request returns their contents.

After reset, the load input gates every access to the registers. The block never stalls its caller. Every write or read request that is qualified by the load input is accepted in the cycle it is presented, so no ready signal exists. Read data comes back one cycle later, marked by a valid strobe that lasts one cycle.

Top module: `ofs_loader`

## Requirements
- R1: On every clock edge with `mrst_n` low, both `ofs_empty` and `ofs_full` load the default value (2^(idx+DEF_SHIFT))-1, where idx = {ld, fsel[1], fsel[0]} as sampled at that edge. With the default parameters this gives 1 for idx 0 and 255 for idx 7.
- R2: The level of `ld` at the last reset edge fixes the programming mode until the next reset: 1 selects serial, 0 selects parallel.
- R3: In serial mode, each edge with `ld` and `wr_en` both high shifts `cfg_si` into the MSB of the active register, and that register shifts right. The first OFS_W steps go to the empty register and the next OFS_W steps go to the full register. After that the sequence returns to the empty register. A bit shifted in first therefore ends up at bit 0.
- R4: In serial mode, `wr_data` and `rd_en` have no effect: the offsets follow only R3, and `rd_valid` stays 0.
- R5: In parallel mode, each edge with `ld` and `wr_en` both high copies `wr_data` into one register. The writes alternate between the two registers, starting with the empty register.
- R6: In parallel mode, each edge with `ld` and `rd_en` both high raises `rd_valid` for exactly the next cycle. In that cycle `rd_data` shows the empty register and the full register in alternation, starting with the empty register. The read pointer is independent of the write pointer. A read returns the value held before any write in the same edge.
- R7: When `ld` is low after reset, `wr_en` and `rd_en` are ignored. The offsets hold their values and `rd_valid` is 0 on the following cycle.
- R8: Reset returns the serial step count and both parallel pointers to the empty register, and it clears `rd_valid` and `rd_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Synchronous master reset, active low; straps are sampled while it is low |
| fsel | input | 2 | Flag-select straps for the default offset index |
| ld | input | 1 | Reset: index MSB and mode strap; afterwards: access enable |
| cfg_si | input | 1 | Serial offset data after reset (shared with the FIFO mode strap) |
| wr_en | input | 1 | Write / shift request |
| wr_data | input | OFS_W | Parallel offset write data |
| rd_en | input | 1 | Parallel read request |
| rd_valid | output | 1 | Read data valid, one cycle after an accepted read |
| rd_data | output | OFS_W | Read-back offset |
| ofs_empty | output | OFS_W | Current almost-empty offset |
| ofs_full | output | OFS_W | Current almost-full offset |

## Verification
The assertions assume three things about the inputs. Reset lasts at least one clock edge. The strap and data inputs are known, never X, at every edge. Inputs change away from the clock edge. The stimulus drives every input on the falling edge from `$urandom` with a fixed seed, and it holds reset low for several edges before each release. Both modes are exercised with random mixes of `ld`, `wr_en` and `rd_en`, so requests with `ld` low and simultaneous reads and writes occur often.

// File: rtl/ofsl_pkg.sv
package ofsl_pkg;
  localparam int NUM_STRAPS = 8;

  // default offset for strap index idx: a mask of idx+shift ones
  function automatic int unsigned def_offset(input int unsigned idx, input int unsigned shift);
    return (32'd1 << (idx + shift)) - 32'd1;
  endfunction
endpackage

// File: rtl/ofsl_ser_seq.sv
module ofsl_ser_seq #(
  parameter int OFS_W = 10
) (
  input  logic clk,
  input  logic mrst_n,
  input  logic step,
  output logic to_full
);
  localparam int CNT_W = $clog2(2 * OFS_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(2 * OFS_W - 1);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(OFS_W);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!mrst_n)      cnt <= '0;
    else if (step)    cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign to_full = (cnt >= HALF);

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!mrst_n)
    cnt <= LAST); // R3

  AST_SEQ_WRAP: assert property (@(posedge clk) disable iff (!mrst_n)
    (step && cnt == LAST) |=> !to_full); // R3
endmodule

// File: rtl/ofsl_par_port.sv
module ofsl_par_port #(
  parameter int OFS_W = 10
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             wr_step,
  input  logic             rd_step,
  input  logic [OFS_W-1:0] ofs_e,
  input  logic [OFS_W-1:0] ofs_f,
  output logic             wsel_full,
  output logic             rd_valid,
  output logic [OFS_W-1:0] rd_data
);
  logic rsel_full;

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      wsel_full <= 1'b0;
      rsel_full <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      if (wr_step) wsel_full <= ~wsel_full;
      rd_valid <= rd_step;
      if (rd_step) begin
        rsel_full <= ~rsel_full;
        rd_data   <= rsel_full ? ofs_f : ofs_e;
      end
    end
  end

  AST_WPTR_TOGGLE: assert property (@(posedge clk) disable iff (!mrst_n)
    wr_step |=> (wsel_full != $past(wsel_full))); // R5

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!mrst_n)
    !rd_step |=> !rd_valid); // R6

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!mrst_n)
    !rd_step |=> $stable(rd_data)); // R6
endmodule

// File: rtl/ofs_loader.sv
module ofs_loader #(
  parameter int OFS_W     = 10,
  parameter int DEF_SHIFT = 1
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic [1:0]       fsel,
  input  logic             ld,
  input  logic             cfg_si,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_data,
  input  logic             rd_en,
  output logic             rd_valid,
  output logic [OFS_W-1:0] rd_data,
  output logic [OFS_W-1:0] ofs_empty,
  output logic [OFS_W-1:0] ofs_full
);
  import ofsl_pkg::*;

  localparam int NSTRAP = NUM_STRAPS;

  logic [OFS_W-1:0] def_tbl [NSTRAP];
  logic [2:0]       strap_idx;
  logic             ser_mode;
  logic             ser_step, par_wr, par_rd;
  logic             to_full, wsel_full;

  generate
    for (genvar g = 0; g < NSTRAP; g++) begin : g_def
      assign def_tbl[g] = OFS_W'(def_offset(g, DEF_SHIFT));
    end
  endgenerate

  assign strap_idx = {ld, fsel};
  assign ser_step  = ser_mode  & ld & wr_en;
  assign par_wr    = !ser_mode & ld & wr_en;
  assign par_rd    = !ser_mode & ld & rd_en;

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      ofs_empty <= def_tbl[strap_idx];
      ofs_full  <= def_tbl[strap_idx];
      ser_mode  <= ld;
    end else if (ser_step) begin
      if (to_full) ofs_full  <= {cfg_si, ofs_full[OFS_W-1:1]};
      else         ofs_empty <= {cfg_si, ofs_empty[OFS_W-1:1]};
    end else if (par_wr) begin
      if (wsel_full) ofs_full  <= wr_data;
      else           ofs_empty <= wr_data;
    end
  end

  ofsl_ser_seq #(.OFS_W(OFS_W)) u_seq (
    .clk     (clk),
    .mrst_n  (mrst_n),
    .step    (ser_step),
    .to_full (to_full)
  );

  ofsl_par_port #(.OFS_W(OFS_W)) u_par (
    .clk       (clk),
    .mrst_n    (mrst_n),
    .wr_step   (par_wr),
    .rd_step   (par_rd),
    .ofs_e     (ofs_empty),
    .ofs_f     (ofs_full),
    .wsel_full (wsel_full),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  AST_RESET_DEFAULT: assert property (@(posedge clk)
    (mrst_n && !$past(mrst_n)) |->
      (ofs_empty == OFS_W'(def_offset(32'($past(strap_idx)), DEF_SHIFT)) && ofs_full == ofs_empty)); // R1

  AST_MODE_FIXED: assert property (@(posedge clk) disable iff (!mrst_n)
    $stable(ser_mode)); // R2

  AST_SER_MSB: assert property (@(posedge clk) disable iff (!mrst_n)
    (ser_step && !to_full) |=> (ofs_empty[OFS_W-1] == $past(cfg_si))); // R3

  AST_NO_RD_SERIAL: assert property (@(posedge clk) disable iff (!mrst_n)
    ser_mode |-> !rd_valid); // R4

  AST_PAR_WRITE: assert property (@(posedge clk) disable iff (!mrst_n)
    par_wr |=> (ofs_empty == $past(wr_data) || ofs_full == $past(wr_data))); // R5

  AST_LD_LOW_HOLD: assert property (@(posedge clk) disable iff (!mrst_n)
    !ld |=> ($stable(ofs_empty) && $stable(ofs_full) && !rd_valid)); // R7
endmodule

// File: tb/ofs_loader_tb.sv
module ofs_loader_tb;
  localparam int W  = 10;
  localparam int SH = 1;

  logic clk = 1'b0;
  logic mrst_n = 1'b0;
  logic [1:0] fsel = '0;
  logic ld = 1'b0, cfg_si = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic rd_valid;
  logic [W-1:0] rd_data, ofs_empty, ofs_full;

  int n_run = 0, n_fail = 0;

  // bench model state
  logic [W-1:0] m_e, m_f, m_rd;
  logic m_ser, m_rv, m_ws, m_rs;
  int m_cnt;

  always #2 clk = ~clk; // 250 MHz

  ofs_loader #(.OFS_W(W), .DEF_SHIFT(SH)) u_dut (
    .clk(clk), .mrst_n(mrst_n), .fsel(fsel), .ld(ld), .cfg_si(cfg_si),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_valid(rd_valid),
    .rd_data(rd_data), .ofs_empty(ofs_empty), .ofs_full(ofs_full)
  );

  function automatic logic [W-1:0] exp_def(input int idx);
    return W'((1 << (idx + SH)) - 1);
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // apply current inputs at one rising edge and advance the model
  task automatic tick();
    logic [W-1:0] pe, pf;
    @(posedge clk);
    pe = m_e; pf = m_f;
    if (!mrst_n) begin
      m_e = exp_def({ld, fsel}); m_f = m_e; m_ser = ld;
      m_cnt = 0; m_ws = 0; m_rs = 0; m_rv = 0; m_rd = '0;
    end else begin
      m_rv = !m_ser && ld && rd_en;
      if (m_rv) begin m_rd = m_rs ? pf : pe; m_rs = !m_rs; end
      if (m_ser && ld && wr_en) begin
        if (m_cnt >= W) m_f = {cfg_si, m_f[W-1:1]};
        else            m_e = {cfg_si, m_e[W-1:1]};
        m_cnt = (m_cnt == 2*W-1) ? 0 : m_cnt + 1;
      end else if (!m_ser && ld && wr_en) begin
        if (m_ws) m_f = wr_data; else m_e = wr_data;
        m_ws = !m_ws;
      end
    end
    @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    chk(tag, ofs_empty, m_e);
    chk(tag, ofs_full, m_f);
    chk(tag, W'(rd_valid), W'(m_rv));
    if (m_rv) chk(tag, rd_data, m_rd);
  endtask

  task automatic do_reset(input logic [2:0] idx);
    @(negedge clk);
    mrst_n = 0; {ld, fsel} = idx; wr_en = 0; rd_en = 0;
    repeat (3) tick();
    mrst_n = 1; ld = 0;
  endtask

  task automatic rand_run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      ld = $urandom_range(0, 3) != 0;
      wr_en = $urandom_range(0, 1);
      rd_en = $urandom_range(0, 1);
      cfg_si = $urandom_range(0, 1);
      wr_data = W'($urandom);
      tick();
      check_all(tag);
    end
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [2*W-1:0] pat;
    void'($urandom(32'd1234));
    // R1: defaults for all eight strap codes, R8 reset values
    for (int k = 0; k < 8; k++) begin
      do_reset(3'(k));
      chk("R1", ofs_empty, exp_def(k));
      chk("R1", ofs_full, exp_def(k));
      chk("R8", W'(rd_valid), '0);
      chk("R8", rd_data, '0);
    end
    // R3: directed serial load, LSB first, empty then full
    do_reset(3'b101);
    pat = 20'hA5C3E;
    ld = 1; wr_en = 1;
    for (int b = 0; b < 2*W; b++) begin cfg_si = pat[b]; tick(); end
    wr_en = 0;
    chk("R3", ofs_empty, pat[W-1:0]);
    chk("R3", ofs_full, pat[2*W-1:W]);
    // R4: parallel data and reads ignored in serial mode
    wr_data = '1; rd_en = 1; cfg_si = 0; tick(); rd_en = 0;
    chk("R4", W'(rd_valid), '0);
    chk("R4", ofs_empty, m_e);
    rand_run(400, "R2 R3 R4 R7");
    // R5/R6: directed parallel writes and reads
    do_reset(3'b010);
    ld = 1; wr_en = 1; wr_data = 10'h155; tick();
    wr_data = 10'h2AA; tick(); wr_en = 0;
    chk("R5", ofs_empty, 10'h155);
    chk("R5", ofs_full, 10'h2AA);
    rd_en = 1; tick();
    chk("R6", W'(rd_valid), 1);
    chk("R6", rd_data, 10'h155);
    tick(); rd_en = 0;
    chk("R6", rd_data, 10'h2AA);
    tick();
    chk("R6", W'(rd_valid), '0);
    // R7: ld low blocks access
    ld = 0; wr_en = 1; rd_en = 1; wr_data = 0; tick();
    chk("R7", ofs_empty, 10'h155);
    chk("R7", W'(rd_valid), '0);
    rand_run(400, "R2 R5 R6 R7");
    // R8: pointers restart after reset
    do_reset(3'b000);
    ld = 1; wr_en = 1; rd_en = 1; wr_data = 10'h0F0; tick();
    wr_en = 0; rd_en = 0;
    chk("R8", ofs_empty, 10'h0F0);
    chk("R8", rd_data, exp_def(0));
    finish_run();
  end
endmodule